// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible control store for one port of up to 32 general-purpose pins. A processor reaches it over a simple word bus: a write strobe with address and data, and a read strobe with address, with read data returned one cycle later. The bank holds per-pin words for:

- the choice between GPIO and peripheral ownership,
- driver enable and output level,
- two alternate-function select words,
- wake enable,
- two pad-configuration words.

Each word is also driven out of the block to the pad ring and the pin multiplexer.

Most control words have two companion addresses. One sets and one clears only the bits written as one, so a driver can change a single pin without a read-modify-write. The pin inputs are resynchronised through two flops and can be read as a read-only word. The pad-configuration words are only stored and exported; their meaning belongs to the pad cells.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is low, and after it is released, every control word is zero. The outputs pin_oe, pin_out, gpio_sel, alt_sel_a, alt_sel_b, wake_en, pad_cfg_a, pad_cfg_b and rdata are therefore all zero.
- R2: A write to a word's base offset replaces the whole word, and the exported output follows after that clock edge. The base offsets are 0x00 GPIO select, 0x0C driver enable, 0x18 output level, 0x4C wake enable, 0x60 pad config A, 0x64 pad config B, 0x68 alternate select A and 0x74 alternate select B. A read of a base offset returns the word.
- R3: A write to base+4 of the GPIO select, driver enable, output level, wake enable and both alternate-select words sets each bit written as 1. The other bits keep their value.
- R4: A write to base+8 of those same words clears each bit written as 1. The other bits keep their value.
- R5: Set and clear offsets read back as zero.
- R6: Offset 0x24 returns pin_in after a two-flop synchronizer. A pin change made just before clock edge k is returned by a read issued at edge k+2, and a read issued at edge k or k+1 still returns the old level. Writes to 0x24 change nothing.
- R7: Any other offset, including misaligned ones, reads as zero, and a write to it changes no control word.
- R8: pin_oe is the bitwise AND of the GPIO select word (1 means GPIO owns the pin) and the driver enable word. pin_out is the output level word.
- R9: rdata carries the addressed word in the cycle after a clock edge that sampled rd_en high. It is zero after any edge that sampled rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte offset of the word accessed |
| wdata | input | PINS | Write data |
| rdata | output | PINS | Registered read data |
| pin_in | input | PINS | Pin levels from the pads |
| pin_out | output | PINS | Output level per pin |
| pin_oe | output | PINS | Driver enable per pin |
| gpio_sel | output | PINS | 1 = GPIO owns the pin, 0 = peripheral |
| alt_sel_a | output | PINS | Alternate select A (0 primary, 1 secondary) |
| alt_sel_b | output | PINS | Alternate select B (0 primary, 1 secondary) |
| wake_en | output | PINS | Wake enable per pin |
| pad_cfg_a | output | PINS | Stored pad configuration word A |
| pad_cfg_b | output | PINS | Stored pad configuration word B |

## Verification
The bench builds the bank with PINS=32 and AW=8. The full 32-bit width makes every set and clear operation exercise all bit positions with random masks. The 8-bit offset space puts the unmapped gaps, the tail above the last word and misaligned offsets all within reach of random accesses. A reference model tracks the effect of each write on every word, and each read, pin output and exported word is compared against it. A directed sequence measures the synchronizer latency on the input word.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] gpio_sel,
  output logic [PINS-1:0] alt_sel_a,
  output logic [PINS-1:0] alt_sel_b,
  output logic [PINS-1:0] wake_en,
  output logic [PINS-1:0] pad_cfg_a,
  output logic [PINS-1:0] pad_cfg_b
);
  localparam logic [AW-1:0] OFF_SEL  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_DRV  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_LVL  = AW'(8'h18);
  localparam logic [AW-1:0] OFF_IN   = AW'(8'h24);
  localparam logic [AW-1:0] OFF_WAKE = AW'(8'h4C);
  localparam logic [AW-1:0] OFF_PADA = AW'(8'h60);
  localparam logic [AW-1:0] OFF_PADB = AW'(8'h64);
  localparam logic [AW-1:0] OFF_ALTA = AW'(8'h68);
  localparam logic [AW-1:0] OFF_ALTB = AW'(8'h74);
  localparam logic [AW-1:0] STEP_SET = AW'(8'h04);
  localparam logic [AW-1:0] STEP_CLR = AW'(8'h08);

  logic [PINS-1:0] sel_q, drv_q, lvl_q, wake_q, pada_q, padb_q, alta_q, altb_q;
  logic [PINS-1:0] sync_a, sync_b;
  logic [PINS-1:0] rd_word;

  function automatic logic [PINS-1:0] next_word(
    input logic [PINS-1:0] cur,
    input logic [AW-1:0]   a,
    input logic [AW-1:0]   base,
    input logic [PINS-1:0] d
  );
    if (a == base)            return d;
    if (a == base + STEP_SET) return cur | d;
    if (a == base + STEP_CLR) return cur & ~d;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      drv_q  <= '0;
      lvl_q  <= '0;
      wake_q <= '0;
      pada_q <= '0;
      padb_q <= '0;
      alta_q <= '0;
      altb_q <= '0;
    end else if (wr_en) begin
      sel_q  <= next_word(sel_q,  addr, OFF_SEL,  wdata);
      drv_q  <= next_word(drv_q,  addr, OFF_DRV,  wdata);
      lvl_q  <= next_word(lvl_q,  addr, OFF_LVL,  wdata);
      wake_q <= next_word(wake_q, addr, OFF_WAKE, wdata);
      alta_q <= next_word(alta_q, addr, OFF_ALTA, wdata);
      altb_q <= next_word(altb_q, addr, OFF_ALTB, wdata);
      if (addr == OFF_PADA) pada_q <= wdata;
      if (addr == OFF_PADB) padb_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
    end
  end

  always_comb begin
    case (addr)
      OFF_SEL:  rd_word = sel_q;
      OFF_DRV:  rd_word = drv_q;
      OFF_LVL:  rd_word = lvl_q;
      OFF_IN:   rd_word = sync_b;
      OFF_WAKE: rd_word = wake_q;
      OFF_PADA: rd_word = pada_q;
      OFF_PADB: rd_word = padb_q;
      OFF_ALTA: rd_word = alta_q;
      OFF_ALTB: rd_word = altb_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_word : '0;
  end

  assign pin_oe    = sel_q & drv_q;
  assign pin_out   = lvl_q;
  assign gpio_sel  = sel_q;
  assign alt_sel_a = alta_q;
  assign alt_sel_b = altb_q;
  assign wake_en   = wake_q;
  assign pad_cfg_a = pada_q;
  assign pad_cfg_b = padb_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [PINS-1:0] wdata,
  input logic [PINS-1:0] rdata,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] gpio_sel,
  input logic [PINS-1:0] alt_sel_a,
  input logic [PINS-1:0] wake_en
);
  function automatic logic is_alias(input logic [AW-1:0] a);
    case (a)
      AW'(8'h04), AW'(8'h08), AW'(8'h10), AW'(8'h14),
      AW'(8'h1C), AW'(8'h20), AW'(8'h50), AW'(8'h54),
      AW'(8'h6C), AW'(8'h70), AW'(8'h78), AW'(8'h7C): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && rdata == '0 && gpio_sel == '0));

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h04)) |=> ((gpio_sel & $past(wdata)) == $past(wdata)));

  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h14)) |=> ((pin_oe & $past(wdata)) == '0));

  assert_alias_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_alias(addr)) |=> (rdata == '0));

  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h30)) |=> ($stable(gpio_sel) && $stable(alt_sel_a) && $stable(wake_en)));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PINS(PINS), .AW(AW)) u_chk (.*);

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe, gpio_sel, alt_sel_a, alt_sel_b, wake_en, pad_cfg_a, pad_cfg_b;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_sel, m_drv, m_lvl, m_wake, m_pada, m_padb, m_alta, m_altb, m_in;

  localparam int NOFF = 26;
  localparam logic [7:0] OFFS [NOFF] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
    8'h20, 8'h24, 8'h4C, 8'h50, 8'h54, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h74, 8'h78, 8'h7C,
    8'h30, 8'h44, 8'hC4, 8'hFC, 8'h02};

  gpio_port_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .gpio_sel(gpio_sel), .alt_sel_a(alt_sel_a), .alt_sel_b(alt_sel_b), .wake_en(wake_en),
    .pad_cfg_a(pad_cfg_a), .pad_cfg_b(pad_cfg_b));

  always #4 clk = ~clk;

  function automatic logic [31:0] apply(input logic [31:0] cur, input logic [7:0] a,
                                        input logic [7:0] base, input logic [31:0] d);
    if (a == base) return d;
    if (a == base + 8'h04) return cur | d;
    if (a == base + 8'h08) return cur & ~d;
    return cur;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    m_sel  = apply(m_sel,  a, 8'h00, d);
    m_drv  = apply(m_drv,  a, 8'h0C, d);
    m_lvl  = apply(m_lvl,  a, 8'h18, d);
    m_wake = apply(m_wake, a, 8'h4C, d);
    m_alta = apply(m_alta, a, 8'h68, d);
    m_altb = apply(m_altb, a, 8'h74, d);
    if (a == 8'h60) m_pada = d;
    if (a == 8'h64) m_padb = d;
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_sel;
      8'h0C: return m_drv;
      8'h18: return m_lvl;
      8'h24: return m_in;
      8'h4C: return m_wake;
      8'h60: return m_pada;
      8'h64: return m_padb;
      8'h68: return m_alta;
      8'h74: return m_altb;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h0C, 8'h18, 8'h4C, 8'h60, 8'h64, 8'h68, 8'h74: return "R2";
      8'h24: return "R6";
      8'h04, 8'h08, 8'h10, 8'h14, 8'h1C, 8'h20, 8'h50, 8'h54, 8'h6C, 8'h70, 8'h78, 8'h7C: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic check_outputs(input string req);
    check("R8", "pin_oe", pin_oe, m_sel & m_drv);
    check("R8", "pin_out", pin_out, m_lvl);
    check(req, "gpio_sel", gpio_sel, m_sel);
    check(req, "alt_sel_a", alt_sel_a, m_alta);
    check(req, "alt_sel_b", alt_sel_b, m_altb);
    check(req, "wake_en", wake_en, m_wake);
    check(req, "pad_cfg_a", pad_cfg_a, m_pada);
    check(req, "pad_cfg_b", pad_cfg_b, m_padb);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    {m_sel, m_drv, m_lvl, m_wake, m_pada, m_padb, m_alta, m_altb, m_in} = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1", "rdata in reset", rdata, 32'h0);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      do_read(OFFS[i == 8 ? 15 : i * 2], v);
      check("R1", "word after reset", v, 32'h0);
    end

    // R3 and R4 on the GPIO select word
    do_write(8'h00, 32'h0000_00F0);
    do_write(8'h04, 32'h0000_0F01);
    do_read(8'h00, v);
    check("R3", "set alias on select", v, 32'h0000_0FF1);
    do_write(8'h08, 32'h0000_0031);
    do_read(8'h00, v);
    check("R4", "clear alias on select", v, 32'h0000_0FC0);
    // R8: driver gated by GPIO select
    do_write(8'h0C, 32'hFFFF_FFFF);
    check("R8", "pin_oe gated", pin_oe, 32'h0000_0FC0);
    do_write(8'h14, 32'h0000_0F00);
    check("R4", "pin_oe after drv clear", pin_oe, 32'h0000_00C0);
    do_write(8'h1C, 32'h8000_0001);
    check("R3", "pin_out after set", pin_out, 32'h8000_0001);
    do_write(8'h20, 32'h0000_0001);
    check("R4", "pin_out after clear", pin_out, 32'h8000_0000);
    do_read(8'h1C, v);
    check("R5", "set alias reads zero", v, 32'h0);

    // R9: idle cycle returns zero
    @(negedge clk);
    check("R9", "rdata idle", rdata, 32'h0);

    // R6: synchronizer latency
    @(negedge clk);
    pin_in = 32'hA5A5_1234;
    rd_en = 1'b1; addr = 8'h24;
    @(negedge clk);
    check("R6", "input read at edge k", rdata, 32'h0);
    @(negedge clk);
    check("R6", "input read at edge k+1", rdata, 32'h0);
    @(negedge clk);
    check("R6", "input read at edge k+2", rdata, 32'hA5A5_1234);
    rd_en = 1'b0;
    m_in = 32'hA5A5_1234;
    do_write(8'h24, 32'hFFFF_FFFF);
    check_outputs("R6");
    do_read(8'h24, v);
    check("R6", "input after write", v, 32'hA5A5_1234);

    // R7: unmapped write
    do_write(8'h30, 32'hFFFF_FFFF);
    do_write(8'h02, 32'hFFFF_FFFF);
    check_outputs("R7");
    do_read(8'h30, v);
    check("R7", "unmapped read", v, 32'h0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = OFFS[$urandom % NOFF];
      if ($urandom % 2) begin
        do_write(a, $urandom);
        check_outputs(req_of(a) == "R5" ? "R3" : "R2");
      end else begin
        do_read(a, v);
        check(req_of(a), "random read", v, model_read(a));
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule